// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Guard

This block sits between a PWM source and the gate drivers of one half-bridge leg. It takes a high-side command (active high), a low-side command (active low) and a shutdown level (active low). It produces one enable for each gate. Both enables are held off in four cases: shutdown, a request for both switches at once, a request for neither switch, and reset. When control passes from one switch to the other, the incoming switch is held off for a programmable number of clock cycles after the outgoing one drops.

Because the low-side command is inverted, both command pins can be tied to a single PWM line. A high level then selects the high-side switch and a low level selects the low-side switch, and the block inserts the dead band at every edge. All three control inputs are treated as asynchronous and pass through a two-stage synchroniser before the decision logic.

Top module: `hb_gate_guard`

## Requirements
- R1: While reset is asserted, `hs_gate` and `ls_gate` are 0 and `both_off` is 1. After reset, the dead-time counter starts already expired, so the first turn-on waits for no dead band.
- R2: With `off_n` = 0, both gate enables are 0 whatever the two command inputs are.
- R3: With `off_n` = 1, `hi_cmd` = 1 and `lo_cmd_n` = 0 (both switches requested), both gate enables are 0.
- R4: With `off_n` = 1, `hi_cmd` = 0 and `lo_cmd_n` = 1 (no switch requested), both gate enables are 0.
- R5: With `off_n` = 1, `hi_cmd` = 1 and `lo_cmd_n` = 1, only `hs_gate` is driven to 1.
- R6: With `off_n` = 1, `hi_cmd` = 0 and `lo_cmd_n` = 0, only `ls_gate` is driven to 1.
- R7: When no dead band is pending, a change on any control input reaches the gate outputs on the third rising clock edge after it is applied.
- R8: On a handover in either direction, the incoming gate rises exactly `DEAD_CYC` cycles after the outgoing gate falls, with both gates low in between.
- R9: If a gate turns off and the same gate is then requested again, with the opposite gate never on in between, it turns on again with no dead band.
- R10: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R11: When both command pins are driven from one line, the outputs switch in a complementary way with the dead band. A dip shorter than the dead band never turns the opposite gate on.
- R12: `both_off` is 1 exactly when both gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| off_n | input | 1 | Shutdown level, active low, asynchronous |
| hi_cmd | input | 1 | High-side command, active high, asynchronous |
| lo_cmd_n | input | 1 | Low-side command, active low, asynchronous |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| both_off | output | 1 | Both gate enables are low |

## Verification
Every input change passes two synchroniser flops and then the output register, so a response with no dead band pending is due on the third rising edge after the stimulus. A handover adds exactly `DEAD_CYC` further edges before the incoming gate rises. The bench drives inputs on falling edges and samples on falling edges. Table vectors wait well beyond the worst-case settle time. The directed latency and dead-band tests count edges one by one and compare the edge index of each output change against 3 and 3 + `DEAD_CYC`. The truth-table assertions look back exactly three samples, and only once three post-reset edges have passed.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_LOW  = 2'd1,
        SIDE_HIGH = 2'd2
    } side_t;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic  off_n,
    input  logic  hi_cmd,
    input  logic  lo_cmd_n,
    output side_t req
);
    always_comb begin
        req = SIDE_NONE;
        if (off_n) begin
            unique case ({hi_cmd, lo_cmd_n})
                2'b11:   req = SIDE_HIGH;  // high side alone
                2'b00:   req = SIDE_LOW;   // low side alone
                default: req = SIDE_NONE;  // overlap or idle
            endcase
        end
    end
endmodule

// File: rtl/hbg_deadband.sv
module hbg_deadband
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  side_t req,
    output logic  hs_gate,
    output logic  ls_gate
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

    typedef struct packed {
        logic          hs;
        logic          ls;
        side_t         last;
        logic [CW-1:0] cnt;
    } db_state_t;

    db_state_t st_d, st_q;
    logic      open;

    always_comb begin
        st_d = st_q;
        open = (st_q.cnt >= DEAD_V);
        st_d.hs = (req == SIDE_HIGH) && ((st_q.last != SIDE_LOW) || open);
        st_d.ls = (req == SIDE_LOW) && ((st_q.last != SIDE_HIGH) || open);
        if (st_d.hs)      st_d.last = SIDE_HIGH;
        else if (st_d.ls) st_d.last = SIDE_LOW;
        if (st_d.hs || st_d.ls) st_d.cnt = '0;
        else if (!open)         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hs   <= 1'b0;
            st_q.ls   <= 1'b0;
            st_q.last <= SIDE_NONE;
            st_q.cnt  <= DEAD_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_gate = st_q.hs;
    assign ls_gate = st_q.ls;
endmodule

// File: rtl/hb_gate_guard.sv
module hb_gate_guard
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_n,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    output logic hs_gate,
    output logic ls_gate,
    output logic both_off
);
    logic [2:0] raw, syn;
    side_t      req;

    assign raw = {off_n, hi_cmd, lo_cmd_n};

    hbg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    hbg_decode u_dec (
        .off_n(syn[2]), .hi_cmd(syn[1]), .lo_cmd_n(syn[0]), .req(req)
    );

    hbg_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
        .clk(clk), .rst_n(rst_n), .req(req),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    assign both_off = ~(hs_gate | ls_gate);
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int DEAD_CYC = 60
) (
    input logic clk,
    input logic rst_n,
    input logic off_n,
    input logic hi_cmd,
    input logic lo_cmd_n,
    input logic hs_gate,
    input logic ls_gate
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

    logic [1:0]    warm_q;
    logic [CW-1:0] ls_low_q, hs_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q   <= '0;
            ls_low_q <= DEAD_V;
            hs_low_q <= DEAD_V;
        end else begin
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            if (ls_gate) ls_low_q <= '0;
            else if (ls_low_q < DEAD_V) ls_low_q <= ls_low_q + 1'b1;
            if (hs_gate) hs_low_q <= '0;
            else if (hs_low_q < DEAD_V) hs_low_q <= hs_low_q + 1'b1;
        end
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate)); // R10
    AST_HS_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (ls_low_q >= DEAD_V)); // R8
    AST_LS_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (hs_low_q >= DEAD_V)); // R8
    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !$past(off_n, 3)) |-> (!hs_gate && !ls_gate)); // R2
    AST_OVERLAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $past(hi_cmd, 3) && !$past(lo_cmd_n, 3))
        |-> (!hs_gate && !ls_gate)); // R3
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !$past(hi_cmd, 3) && $past(lo_cmd_n, 3))
        |-> (!hs_gate && !ls_gate)); // R4
endmodule

bind hb_gate_guard hbg_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .off_n(off_n), .hi_cmd(hi_cmd),
    .lo_cmd_n(lo_cmd_n), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/tb_hb_gate_guard.sv
`timescale 1ns/1ps
module tb_hb_gate_guard;
    localparam int DT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic off_n = 1'b0, hi_cmd = 1'b0, lo_cmd_n = 1'b1;
    logic hs_gate, ls_gate, both_off;
    int   errors = 0, checks = 0, overlaps = 0;

    always #2 clk = ~clk;

    hb_gate_guard #(.DEAD_CYC(DT)) dut (
        .clk(clk), .rst_n(rst_n), .off_n(off_n), .hi_cmd(hi_cmd),
        .lo_cmd_n(lo_cmd_n), .hs_gate(hs_gate), .ls_gate(ls_gate),
        .both_off(both_off)
    );

    always @(negedge clk) if (hs_gate && ls_gate) overlaps++;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic o, logic h, logic l);
        off_n = o; hi_cmd = h; lo_cmd_n = l;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // {off_n, hi_cmd, lo_cmd_n, exp_hs, exp_ls}
    localparam logic [4:0] VEC [10] = '{
        5'b10100,  // R4 idle
        5'b10001,  // R6 low side
        5'b11110,  // R5 high side after dead band
        5'b11000,  // R3 overlap
        5'b01100,  // R2 shutdown
        5'b00000,  // R2 shutdown
        5'b01000,  // R2 shutdown
        5'b10001,  // R6 low side
        5'b10100,  // R4 idle
        5'b11110   // R5 high side
    };
    localparam int TAG [10] = '{4, 6, 5, 3, 2, 2, 2, 6, 4, 5};

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        int fall_k, rise_k, seen;
        // R1 reset state
        edges(3);
        chk("R1 hs in reset", hs_gate, 0);
        chk("R1 ls in reset", ls_gate, 0);
        chk("R12 both_off in reset", both_off, 1);
        drive(1'b1, 1'b0, 1'b1);
        rst_n = 1'b1;
        edges(5);

        // R7 / R1: first turn-on after reset, no dead band, third edge
        drive(1'b1, 1'b1, 1'b1);
        edges(2);
        chk("R7 hs before third edge", hs_gate, 0);
        edges(1);
        chk("R7 R1 hs on third edge", hs_gate, 1);

        // table walk
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][4], VEC[i][3], VEC[i][2]);
            edges(DT + 6);
            chk($sformatf("R%0d hs vec%0d", TAG[i], i), hs_gate, VEC[i][1]);
            chk($sformatf("R%0d ls vec%0d", TAG[i], i), ls_gate, VEC[i][0]);
            chk($sformatf("R12 both_off vec%0d", i), both_off,
                int'(!(VEC[i][1] | VEC[i][0])));
        end

        // R8 high to low handover (hs currently on)
        drive(1'b1, 1'b0, 1'b0);
        fall_k = -1; rise_k = -1;
        for (int k = 1; k <= DT + 8; k++) begin
            edges(1);
            if (fall_k < 0 && !hs_gate) fall_k = k;
            if (rise_k < 0 && ls_gate) rise_k = k;
        end
        chk("R8 hs falls edge", fall_k, 3);
        chk("R8 ls rises edge", rise_k, 3 + DT);

        // R8 low to high handover
        drive(1'b1, 1'b1, 1'b1);
        fall_k = -1; rise_k = -1;
        for (int k = 1; k <= DT + 8; k++) begin
            edges(1);
            if (fall_k < 0 && !ls_gate) fall_k = k;
            if (rise_k < 0 && hs_gate) rise_k = k;
        end
        chk("R8 ls falls edge", fall_k, 3);
        chk("R8 hs rises edge", rise_k, 3 + DT);

        // R9 same side again after idle, no dead band
        drive(1'b1, 1'b0, 1'b1);
        edges(4);
        chk("R9 hs off in idle", hs_gate, 0);
        drive(1'b1, 1'b1, 1'b1);
        edges(3);
        chk("R9 hs back on third edge", hs_gate, 1);

        // R11 tied line: long halves, then a short dip
        for (int p = 0; p < 4; p++) begin
            logic lvl;
            lvl = p[0];
            drive(1'b1, lvl, lvl);
            edges(DT + 6);
            chk("R11 tied hs", hs_gate, int'(lvl));
            chk("R11 tied ls", ls_gate, int'(!lvl));
        end
        drive(1'b1, 1'b1, 1'b1);
        edges(DT + 6);
        seen = 0;
        drive(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < DT / 2; k++) begin
            edges(1);
            if (ls_gate) seen++;
        end
        drive(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < DT + 6; k++) begin
            edges(1);
            if (ls_gate) seen++;
        end
        chk("R11 short dip ls stays off", seen, 0);
        chk("R11 hs restored after dip", hs_gate, 1);

        // R2 shutdown mid dead band
        drive(1'b1, 1'b0, 1'b0);
        edges(5);
        drive(1'b0, 1'b0, 1'b0);
        edges(DT + 6);
        chk("R2 ls held off by shutdown", ls_gate, 0);

        chk("R10 no overlap seen", overlaps, 0);
        summary();
    end
endmodule